// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is a 16-bit counting engine with a paired 16-bit capture/reload register. The counter runs in timer mode, on every cycle its count-enable input is high, or in counter mode, on falling edges of an external count pin. Five behaviours share the counter: capture, auto-reload counting up, auto-reload counting up or down, baud-rate tick generation and clock output. The external trigger pin takes a different role in each of them. It can capture the count, force a reload, only raise a flag, or set the count direction.

Software configures the block with byte writes on a small register bus. It reads the count and the capture/reload value on two output buses. An overflow flag and an external-event flag are merged into a single interrupt request, which an enable bit gates. A one-cycle baud tick goes to a serial port and a toggling clock-out pin is available. The serial port and the interrupt controller are outside the block.

Top module: `tmr16_multi`

## Requirements
- R1: After reset the count and the capture/reload value are 0, both flags are clear, and irq, baudTick and clkOut are low.
- R2: With run set (control bit 0) and timer mode selected (control bit 1 clear), the count rises by one on every clock cycle in which cntEn is high. With run clear the count holds.
- R3: In counter mode (control bit 1 set) the count rises by one for each falling edge of cntPin, seen after a two-flop synchronizer. cntEn has no effect in this mode.
- R4: Capture mode applies when control bit 2 is set and neither baud bit nor the clock-out bit is set. In this mode an increment from 0xFFFF wraps to 0x0000, sets the overflow flag and leaves the capture/reload value unchanged.
- R5: In capture mode, a synchronized falling edge on trgPin with the trigger-enable bit set (control bit 3) sets the external flag and copies the count into the capture/reload register. This also happens with run clear. When an increment falls in the same cycle, the value captured is the count before that increment. With the trigger-enable bit clear, the edge changes nothing.
- R6: In reload mode (control bit 2 clear, mode bit 0 clear), an increment from 0xFFFF loads the capture/reload value and sets the overflow flag. A qualified trigger edge sets the external flag and loads the same value.
- R7: Baud mode is selected when control bit 4 or bit 5 is set, and it takes priority over every other mode. In baud mode an overflow loads the capture/reload value and drives baudTick high for exactly one cycle. The overflow flag is not set. A qualified trigger edge only sets the external flag.
- R8: Up/down mode is reload mode with mode bit 0 set. trgPin high counts up and trgPin low counts down. A downward step taken at a count at or below the capture/reload value loads 0xFFFF and sets the overflow flag. Every overflow and every underflow toggles the external flag.
- R9: Clock-out mode is selected by mode bit 1 when neither baud bit is set. Each overflow loads the capture/reload value and toggles clkOut, and the overflow flag is not set.
- R10: irq is high when the irq-enable bit (mode bit 2) is set and either the overflow flag or the external flag is set. The external flag does not count toward irq in up/down mode.
- R11: Writing 0 to control bit 6 clears the overflow flag, and writing 0 to control bit 7 clears the external flag. Writing 1 to either bit leaves its flag unchanged. If hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R12: Register map on wrAddr: 0 is control, 1 is mode, 2 and 3 are the count low and high bytes, 4 and 5 are the capture/reload low and high bytes. A byte write shows on countVal or rcapVal on the next cycle and wins over any hardware update in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cntEn | input | 1 | Count enable in timer mode |
| cntPin | input | 1 | External count pin (asynchronous) |
| trgPin | input | 1 | External trigger / direction pin (asynchronous) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| ovfFlag | output | 1 | Overflow flag |
| extFlag | output | 1 | External-event flag |
| irq | output | 1 | Interrupt request |
| baudTick | output | 1 | One-cycle tick on baud-mode overflow |
| clkOut | output | 1 | Clock-out toggle output |
| countVal | output | 16 | Current count |
| rcapVal | output | 16 | Capture/reload register |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a trigger capture and a counter increment. The bench holds cntEn high while it drops trgPin at several offsets from the start of counting. For each offset it computes which synchronized edge performs the capture, and expects the captured value to be the count before that edge's increment and the count to have stepped past it. The second pair is a software flag clear and a hardware overflow. The bench issues the clear-write in the same cycle as the increment that wraps 0xFFFF, and expects the flag to stay set.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  // register addresses
  localparam int unsigned REG_CTL    = 0;
  localparam int unsigned REG_MODE   = 1;
  localparam int unsigned REG_CNT_LO = 2;
  localparam int unsigned REG_CNT_HI = 3;
  localparam int unsigned REG_RLD_LO = 4;
  localparam int unsigned REG_RLD_HI = 5;

  // control register bits
  localparam int unsigned BIT_RUN = 0;
  localparam int unsigned BIT_CT  = 1;
  localparam int unsigned BIT_CAP = 2;
  localparam int unsigned BIT_EXT = 3;
  localparam int unsigned BIT_RX  = 4;
  localparam int unsigned BIT_TX  = 5;
  localparam int unsigned BIT_OVF = 6;
  localparam int unsigned BIT_EXF = 7;

  // mode register bits
  localparam int unsigned BIT_DOWN = 0;
  localparam int unsigned BIT_CKO  = 1;
  localparam int unsigned BIT_IRQE = 2;

  typedef enum logic [2:0] {
    MODE_CAPTURE,
    MODE_RELOAD,
    MODE_UPDOWN,
    MODE_BAUD,
    MODE_CLKOUT
  } tmrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic inc;
    logic dec;
    logic reload;
    logic loadMax;
    logic capture;
    logic wrCntLo;
    logic wrCntHi;
    logic wrRldLo;
    logic wrRldHi;
  } dpStrobe_t;

endpackage

// File: rtl/tmr16_sync.sv
module tmr16_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic level,
  output logic fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[LAST-1:0], pinIn};
  end

  // level is the synchronized pin, chain[LAST] the previous sample of it
  assign level = chain[LAST-1];
  assign fall  = chain[LAST] & ~chain[LAST-1];
endmodule

// File: rtl/tmr16_dp.sv
module tmr16_dp
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [CNT_W/2-1:0] wrData,
  output logic [CNT_W-1:0]   countVal,
  output logic [CNT_W-1:0]   rcapVal,
  output logic               isMax,
  output logic               atOrBelow
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] rcapNext;

  always_comb begin
    cntNext = countVal;
    if (strobe.reload)       cntNext = rcapVal;
    else if (strobe.loadMax) cntNext = '1;
    else if (strobe.inc)     cntNext = countVal + CNT_W'(1);
    else if (strobe.dec)     cntNext = countVal - CNT_W'(1);
    // software byte writes take priority
    if (strobe.wrCntLo) cntNext[HALF-1:0]     = wrData;
    if (strobe.wrCntHi) cntNext[CNT_W-1:HALF] = wrData;
  end

  always_comb begin
    rcapNext = rcapVal;
    if (strobe.capture) rcapNext = countVal;
    if (strobe.wrRldLo) rcapNext[HALF-1:0]     = wrData;
    if (strobe.wrRldHi) rcapNext[CNT_W-1:HALF] = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
      rcapVal  <= '0;
    end else begin
      countVal <= cntNext;
      rcapVal  <= rcapNext;
    end
  end

  assign isMax     = &countVal;
  assign atOrBelow = countVal <= rcapVal;
endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cntEn,
  input  logic               cntFall,
  input  logic               trgLevel,
  input  logic               trgFall,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [CNT_W/2-1:0] wrData,
  input  logic               isMax,
  input  logic               atOrBelow,
  output dpStrobe_t          strobe,
  output logic               ovfFlag,
  output logic               extFlag,
  output logic               irq,
  output logic               baudTick,
  output logic               clkOut
);
  logic runEn, ctSel, capSel, extEn, rxClk, txClk;
  logic downEn, clkOutEn, irqEn;
  tmrMode_e mode;

  logic wrCtl, wrMode;
  logic tick, trgQual, upDir, ovfEvt, unfEvt;
  logic ovfSet, extSet, extTog;
  logic ovfKept, extKept;

  assign wrCtl  = wrEn && (wrAddr == ADDR_W'(REG_CTL));
  assign wrMode = wrEn && (wrAddr == ADDR_W'(REG_MODE));

  // configuration bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      ctSel    <= 1'b0;
      capSel   <= 1'b0;
      extEn    <= 1'b0;
      rxClk    <= 1'b0;
      txClk    <= 1'b0;
      downEn   <= 1'b0;
      clkOutEn <= 1'b0;
      irqEn    <= 1'b0;
    end else begin
      if (wrCtl) begin
        runEn  <= wrData[BIT_RUN];
        ctSel  <= wrData[BIT_CT];
        capSel <= wrData[BIT_CAP];
        extEn  <= wrData[BIT_EXT];
        rxClk  <= wrData[BIT_RX];
        txClk  <= wrData[BIT_TX];
      end
      if (wrMode) begin
        downEn   <= wrData[BIT_DOWN];
        clkOutEn <= wrData[BIT_CKO];
        irqEn    <= wrData[BIT_IRQE];
      end
    end
  end

  // mode decode, baud first, then clock-out, then capture/reload
  always_comb begin
    if (rxClk | txClk)  mode = MODE_BAUD;
    else if (clkOutEn)  mode = MODE_CLKOUT;
    else if (capSel)    mode = MODE_CAPTURE;
    else if (downEn)    mode = MODE_UPDOWN;
    else                mode = MODE_RELOAD;
  end

  assign tick    = runEn & (ctSel ? cntFall : cntEn);
  assign trgQual = extEn & trgFall;
  assign upDir   = (mode == MODE_UPDOWN) ? trgLevel : 1'b1;
  assign ovfEvt  = tick & upDir & isMax;
  assign unfEvt  = tick & ~upDir & atOrBelow;

  always_comb begin
    strobe         = '0;
    strobe.inc     = tick & upDir;
    strobe.dec     = tick & ~upDir;
    strobe.loadMax = unfEvt;
    strobe.capture = trgQual & (mode == MODE_CAPTURE);
    strobe.reload  = (ovfEvt & (mode != MODE_CAPTURE))
                   | (trgQual & (mode == MODE_RELOAD));
    strobe.wrCntLo = wrEn && (wrAddr == ADDR_W'(REG_CNT_LO));
    strobe.wrCntHi = wrEn && (wrAddr == ADDR_W'(REG_CNT_HI));
    strobe.wrRldLo = wrEn && (wrAddr == ADDR_W'(REG_RLD_LO));
    strobe.wrRldHi = wrEn && (wrAddr == ADDR_W'(REG_RLD_HI));
  end

  always_comb begin
    ovfSet = (ovfEvt & (mode == MODE_CAPTURE || mode == MODE_RELOAD ||
                        mode == MODE_UPDOWN)) | unfEvt;
    extSet = trgQual & (mode != MODE_UPDOWN);
    extTog = (mode == MODE_UPDOWN) & (ovfEvt | unfEvt);
  end

  // flags: software clears by writing zero, hardware set wins
  assign ovfKept = ovfFlag & ~(wrCtl & ~wrData[BIT_OVF]);
  assign extKept = extFlag & ~(wrCtl & ~wrData[BIT_EXF]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag  <= 1'b0;
      extFlag  <= 1'b0;
      baudTick <= 1'b0;
      clkOut   <= 1'b0;
    end else begin
      ovfFlag  <= ovfSet | ovfKept;
      extFlag  <= extSet | (extTog ? ~extKept : extKept);
      baudTick <= ovfEvt & (mode == MODE_BAUD);
      clkOut   <= clkOut ^ (ovfEvt & (mode == MODE_CLKOUT));
    end
  end

  assign irq = irqEn & (ovfFlag | (extFlag & (mode != MODE_UPDOWN)));
endmodule

// File: rtl/tmr16_multi.sv
module tmr16_multi
  import tmr16_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int SYNC_N = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cntEn,
  input  logic               cntPin,
  input  logic               trgPin,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [CNT_W/2-1:0] wrData,
  output logic               ovfFlag,
  output logic               extFlag,
  output logic               irq,
  output logic               baudTick,
  output logic               clkOut,
  output logic [CNT_W-1:0]   countVal,
  output logic [CNT_W-1:0]   rcapVal
);
  logic      cntLevel, cntFall, trgLevel, trgFall;
  logic      isMax, atOrBelow;
  dpStrobe_t strobe;

  tmr16_sync #(.STAGES(SYNC_N)) cntSync_i (
    .clk(clk), .rstN(rstN), .pinIn(cntPin), .level(cntLevel), .fall(cntFall)
  );

  tmr16_sync #(.STAGES(SYNC_N)) trgSync_i (
    .clk(clk), .rstN(rstN), .pinIn(trgPin), .level(trgLevel), .fall(trgFall)
  );

  tmr16_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cntEn(cntEn),
    .cntFall(cntFall & ~cntLevel), .trgLevel(trgLevel), .trgFall(trgFall),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .isMax(isMax), .atOrBelow(atOrBelow), .strobe(strobe),
    .ovfFlag(ovfFlag), .extFlag(extFlag), .irq(irq),
    .baudTick(baudTick), .clkOut(clkOut)
  );

  tmr16_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .countVal(countVal), .rcapVal(rcapVal),
    .isMax(isMax), .atOrBelow(atOrBelow)
  );
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk
  import tmr16_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [CNT_W/2-1:0] wrData,
  input logic               ovfFlag,
  input logic               extFlag,
  input logic               irq,
  input logic               baudTick,
  input logic               clkOut,
  input logic [CNT_W-1:0]   countVal,
  input logic [CNT_W-1:0]   rcapVal
);
  localparam int HALF = CNT_W / 2;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (countVal == '0 && rcapVal == '0 && !ovfFlag && !extFlag &&
               !irq && !baudTick && !clkOut));

  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ovfFlag || extFlag));

  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ovfFlag) && !ovfFlag) |->
      $past(wrEn && wrAddr == ADDR_W'(REG_CTL) && !wrData[BIT_OVF]));

  a_r12_rld_lo_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(REG_RLD_LO)) |=> rcapVal[HALF-1:0] == $past(wrData));

  a_r12_cnt_hi_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(REG_CNT_HI)) |=> countVal[CNT_W-1:HALF] == $past(wrData));
endmodule

bind tmr16_multi tmr16_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/tmr16_multi_tb_top.sv
module tmr16_multi_tb_top;
  logic        clk = 1'b0;
  logic        rstN, cntEn, cntPin, trgPin, wrEn;
  logic [2:0]  wrAddr;
  logic [7:0]  wrData;
  logic        ovfFlag, extFlag, irq, baudTick, clkOut;
  logic [15:0] countVal, rcapVal;

  int nChecks = 0;
  int nFails  = 0;
  int baudCnt = 0;
  int togCnt  = 0;
  logic clkPrev = 1'b0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  tmr16_multi dut_i (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .cntPin(cntPin), .trgPin(trgPin),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ovfFlag(ovfFlag), .extFlag(extFlag), .irq(irq), .baudTick(baudTick),
    .clkOut(clkOut), .countVal(countVal), .rcapVal(rcapVal)
  );

  always @(posedge clk) begin
    if (baudTick) baudCnt++;
    if (clkOut != clkPrev) togCnt++;
    clkPrev = clkOut;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setCnt(input logic [15:0] v);
    wr(3'd2, v[7:0]); wr(3'd3, v[15:8]);
  endtask

  task automatic setRld(input logic [15:0] v);
    wr(3'd4, v[7:0]); wr(3'd5, v[15:8]);
  endtask

  function automatic logic [7:0] ctlB(input bit run, ct, cap, ext, rx, tx, keep);
    return {keep, keep, tx, rx, ext, cap, ct, run};
  endfunction

  function automatic logic [15:0] nextUp(input logic [15:0] c, input logic [15:0] rl);
    return (c == 16'hFFFF) ? rl : c + 16'd1;
  endfunction

  task automatic ticks(input int n);
    @(negedge clk);
    cntEn = 1'b1;
    repeat (n) @(negedge clk);
    cntEn = 1'b0;
  endtask

  task automatic pulseTrg();
    @(negedge clk); trgPin = 1'b0;
    repeat (3) @(negedge clk); trgPin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseCnt();
    @(negedge clk); cntPin = 1'b0;
    repeat (3) @(negedge clk); cntPin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cntEn = 1'b0; cntPin = 1'b1; trgPin = 1'b1;
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", countVal, 0);
    chk("R1 rcap", rcapVal, 0);
    chk("R1 flags/irq/tick/clkOut", {ovfFlag, extFlag, irq, baudTick, clkOut}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R12 register writes
    setCnt(16'h1234); chk("R12 count write", countVal, 16'h1234);
    setRld(16'hBEEF); chk("R12 reload write", rcapVal, 16'hBEEF);

    // R2 timer mode sweep
    wr(3'd0, ctlB(1, 0, 1, 0, 0, 0, 0));
    for (int n = 0; n < 7; n++) begin
      setCnt(16'(16 * n));
      if (n > 0) ticks(n);
      chk("R2 timer count", countVal, 16 * n + n);
    end
    wr(3'd0, ctlB(0, 0, 1, 0, 0, 0, 0));
    setCnt(16'h0050);
    ticks(5);
    chk("R2 run clear holds", countVal, 16'h0050);

    // R3 counter mode, cntEn ignored
    wr(3'd0, ctlB(1, 1, 1, 0, 0, 0, 0));
    setCnt(16'h0000);
    @(negedge clk); cntEn = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      pulseCnt();
      chk("R3 pin edge count", countVal, k);
    end
    cntEn = 1'b0;

    // R4 capture-mode overflow wraps
    wr(3'd0, ctlB(1, 0, 1, 0, 0, 0, 0));
    setRld(16'h5555); setCnt(16'hFFFD);
    ticks(3);
    chk("R4 wrap count", countVal, 16'h0000);
    chk("R4 ovf set", ovfFlag, 1);
    chk("R4 rcap unchanged", rcapVal, 16'h5555);
    ticks(1);
    chk("R11 ovf sticky", ovfFlag, 1);

    // R11 software clear rules
    wr(3'd0, ctlB(1, 0, 1, 0, 0, 0, 1));
    chk("R11 write one keeps", ovfFlag, 1);
    // R10 irq gating
    wr(3'd1, 8'h00); chk("R10 irq disabled", irq, 0);
    wr(3'd1, 8'h04); chk("R10 irq enabled", irq, 1);
    wr(3'd0, ctlB(1, 0, 1, 0, 0, 0, 0));
    chk("R11 write zero clears", ovfFlag, 0);
    chk("R10 irq after clear", irq, 0);
    wr(3'd0, ctlB(1, 0, 1, 0, 0, 0, 1));
    chk("R11 write one does not set", {ovfFlag, extFlag}, 0);
    // hardware set vs software clear in one cycle
    setCnt(16'hFFFF);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd0; wrData = ctlB(1, 0, 1, 0, 0, 0, 0); cntEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; cntEn = 1'b0;
    chk("R11 hw set wins", ovfFlag, 1);
    chk("R4 wrap in same cycle", countVal, 16'h0000);
    wr(3'd1, 8'h00);

    // R5 capture: disabled, then enabled with run clear
    wr(3'd0, ctlB(0, 0, 1, 0, 0, 0, 0));
    setCnt(16'h2468); setRld(16'h0000);
    pulseTrg();
    chk("R5 disabled rcap", rcapVal, 16'h0000);
    chk("R5 disabled ext", extFlag, 0);
    wr(3'd0, ctlB(0, 0, 1, 1, 0, 0, 0));
    pulseTrg();
    chk("R5 capture run clear", rcapVal, 16'h2468);
    chk("R5 ext set", extFlag, 1);
    // capture coinciding with increments
    for (int d = 0; d < 4; d++) begin
      wr(3'd0, ctlB(1, 0, 1, 1, 0, 0, 0));
      setCnt(16'h7000);
      @(negedge clk); cntEn = 1'b1;
      repeat (d) @(negedge clk);
      trgPin = 1'b0;
      repeat (3) @(negedge clk);
      cntEn = 1'b0;
      chk("R5 captured pre-increment", rcapVal, 16'h7000 + d + 2);
      chk("R5 count kept counting", countVal, 16'h7000 + d + 3);
      chk("R5 ext on capture", extFlag, 1);
      trgPin = 1'b1;
      repeat (3) @(negedge clk);
    end

    // R6 reload-up sweep
    wr(3'd1, 8'h00);
    for (int i = 0; i < 4; i++) begin
      logic [15:0] rl, e;
      rl = (i == 0) ? 16'hFFF0 : (i == 1) ? 16'h8000 : (i == 2) ? 16'h0001 : 16'hFFFF;
      wr(3'd0, ctlB(1, 0, 0, 0, 0, 0, 0));
      setRld(rl); setCnt(16'hFFFE);
      ticks(2);
      chk("R6 reload on overflow", countVal, rl);
      chk("R6 ovf set", ovfFlag, 1);
      e = nextUp(nextUp(nextUp(rl, rl), rl), rl);
      ticks(3);
      chk("R6 count after reload", countVal, e);
    end
    wr(3'd0, ctlB(0, 0, 0, 1, 0, 0, 0));
    setCnt(16'h0100); setRld(16'h4321);
    pulseTrg();
    chk("R6 trigger reload", countVal, 16'h4321);
    chk("R6 trigger ext", {extFlag, ovfFlag}, 2'b10);

    // R7 baud mode
    wr(3'd0, ctlB(1, 0, 0, 0, 1, 0, 0));
    setRld(16'hFFFC); setCnt(16'hFFFE);
    @(negedge clk); cntEn = 1'b1;
    @(negedge clk);
    @(negedge clk); cntEn = 1'b0;
    chk("R7 baud tick high", baudTick, 1);
    chk("R7 baud reload", countVal, 16'hFFFC);
    chk("R7 no ovf in baud", ovfFlag, 0);
    @(negedge clk);
    chk("R7 baud tick one cycle", baudTick, 0);
    for (int m = 1; m < 4; m++) begin
      wr(3'd0, ctlB(1, 0, 0, 0, m[0], m[1], 0));
      setCnt(16'hFFFC);
      baudCnt = 0;
      ticks(20);
      @(negedge clk);
      chk("R7 baud tick count", baudCnt, 5);
    end
    wr(3'd0, ctlB(0, 0, 0, 1, 1, 0, 0));
    setCnt(16'h1111); setRld(16'h2222);
    pulseTrg();
    chk("R7 trigger ext only", extFlag, 1);
    chk("R7 trigger no reload", countVal, 16'h1111);

    // R9 clock out
    wr(3'd0, ctlB(1, 0, 0, 0, 0, 0, 0));
    wr(3'd1, 8'h02);
    setRld(16'hFFFE); setCnt(16'hFFFE);
    togCnt = 0;
    ticks(10);
    @(negedge clk);
    chk("R9 toggles", togCnt, 5);
    chk("R9 clkOut level", clkOut, 1);
    chk("R9 reload value", countVal, 16'hFFFE);
    chk("R9 no ovf", ovfFlag, 0);

    // R8 up/down
    wr(3'd1, 8'h05);
    for (int i = 0; i < 3; i++) begin
      logic [15:0] rl;
      rl = (i == 0) ? 16'h0000 : (i == 1) ? 16'h0005 : 16'h0100;
      wr(3'd0, ctlB(1, 0, 0, 0, 0, 0, 0));
      @(negedge clk); trgPin = 1'b0;
      repeat (3) @(negedge clk);
      setRld(rl); setCnt(rl + 16'd2);
      ticks(2);
      chk("R8 count down", countVal, rl);
      chk("R8 no early ovf", ovfFlag, 0);
      ticks(1);
      chk("R8 underflow loads max", countVal, 16'hFFFF);
      chk("R8 underflow flags", {ovfFlag, extFlag}, 2'b11);
      chk("R10 irq on ovf", irq, 1);
      wr(3'd0, ctlB(1, 0, 0, 0, 0, 0, 0) | 8'h80);
      chk("R10 ext ignored in updown", {irq, extFlag}, 2'b01);
      @(negedge clk); trgPin = 1'b1;
      repeat (3) @(negedge clk);
      ticks(1);
      chk("R8 up overflow reload", countVal, rl);
      chk("R8 ext toggled back", {ovfFlag, extFlag}, 2'b10);
    end
    wr(3'd1, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule